// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset until the memory is ready. After reset is released it raises the clock enable, holds the bus at no-operation for a programmable power-up wait, and closes every bank with a precharge-all. It then issues a programmable number of auto-refresh commands (at least eight) and one mode register load. The order of these two steps is fixed at elaboration. When the wait that follows the final step has run out, it raises `init_done` and leaves the bus at no-operation for the controller that takes over.

All waits are parameters counted in clock cycles. The mode register word is built from parameters for CAS latency, burst type, burst length code and single-write mode. A generate choice selects refresh-first or mode-first ordering. Illegal parameter sets, such as fewer than eight refreshes or a command gap under two cycles, stop elaboration.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is 0, the command pins show no-operation (`sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1), `sd_addr` and `sd_ba` are 0, and `init_done` is 0.
- R2: Counting output cycle n as the cycle after the n-th rising clock edge following reset release, `sd_cke` is 1 from cycle 1 onward. Cycles 1 to PWR_WAIT_CYC are no-operation, and the precharge-all appears in cycle PWR_WAIT_CYC+1.
- R3: Precharge-all is driven as `sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=1, `sd_we_n`=0, with `sd_addr` bit 10 set, every other address bit 0, and `sd_ba`=0. It occurs exactly once.
- R4: Auto-refresh is driven as `sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=0, `sd_we_n`=1, with address and bank 0. Exactly N_REFRESH are issued, and consecutive ones start T_RC_CYC cycles apart.
- R5: Mode load is driven with all four command pins at 0 and `sd_ba`=0. `sd_addr` carries the op code: bits 2:0 the burst length code, bit 3 the burst type, bits 6:4 the CAS latency, bit 9 the single-write flag, and all other bits 0.
- R6: With MODE_FIRST=0, the first refresh comes T_RP_CYC cycles after the precharge. The mode load comes T_RC_CYC cycles after the last refresh. `init_done` rises T_MRD_CYC cycles after the mode load.
- R7: With MODE_FIRST=1, the mode load comes T_RP_CYC cycles after the precharge. The first refresh comes T_MRD_CYC cycles after the mode load. `init_done` rises T_RC_CYC cycles after the last refresh.
- R8: Every output cycle after reset that does not carry a command named in R3 to R5 is no-operation with `sd_addr` and `sd_ba` at 0.
- R9: `init_done` is 0 before the cycle given by R6 or R7, and from that cycle it stays 1 until reset, with the bus at no-operation.
- R10: Asserting `rst_n` low at any point in the sequence returns the outputs to the R1 state at once. Releasing it restarts the whole sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed address; carries the precharge-all flag and the mode op code |
| sd_ba | output | BANK_W | Bank select, 0 throughout initialization |
| init_done | output | 1 | High once initialization has completed |

## Verification
The bench builds two instances side by side.

The first uses refresh-first ordering, a 5-cycle power-up wait, gaps of 2/3/2 cycles and the minimum eight refreshes. Its op code is CAS latency 3, interleaved burst of eight, with single-write set.

The second uses mode-first ordering, a 3-cycle wait, gaps of 3/4/3 cycles and nine refreshes. Its op code is CAS latency 2, sequential burst of four.

These short waits make the entire schedule small enough to check pin-by-pin in every cycle against a schedule worked out arithmetically in the bench. Both orderings, both op-code layouts, the refresh-count boundary and a reset applied mid-sequence are therefore all covered in one run.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_POWERUP,
      PH_PRECHARGE,
      PH_REFRESH,
      PH_MODE,
      PH_GAP,
      PH_DONE
   } boot_phase_e;

   typedef enum logic [1:0] {
      CMD_NOP,
      CMD_PRE,
      CMD_REF,
      CMD_MRS
   } boot_cmd_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_boot_opcode.sv
module sdram_boot_opcode #(
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned CAS_LAT        = 2,
   parameter int unsigned BURST_TYPE     = 0,
   parameter int unsigned BURST_LEN_CODE = 2,
   parameter int unsigned SINGLE_WRITE   = 0
) (
   output logic [ADDR_W-1:0] mode_word
);

   localparam logic [2:0] BL_BITS = 3'(BURST_LEN_CODE);
   localparam logic [2:0] CL_BITS = 3'(CAS_LAT);
   localparam logic       BT_BIT  = 1'(BURST_TYPE);
   localparam logic       SW_BIT  = 1'(SINGLE_WRITE);

   if (CAS_LAT < 1 || CAS_LAT > 3) begin : g_bad_cl
      $error("sdram_boot_opcode: CAS_LAT must be 1, 2 or 3");
   end
   if (BURST_TYPE > 1 || SINGLE_WRITE > 1) begin : g_bad_flag
      $error("sdram_boot_opcode: BURST_TYPE and SINGLE_WRITE are single bits");
   end
   if (!(BURST_LEN_CODE <= 3 || (BURST_LEN_CODE == 7 && BURST_TYPE == 0))) begin : g_bad_bl
      $error("sdram_boot_opcode: burst length code not legal for the burst type");
   end

   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      if (b < 3) begin : g_bl
         assign mode_word[b] = BL_BITS[b];
      end else if (b == 3) begin : g_bt
         assign mode_word[b] = BT_BIT;
      end else if (b < 7) begin : g_cl
         assign mode_word[b] = CL_BITS[b-4];
      end else if (b == 9) begin : g_sw
         assign mode_word[b] = SW_BIT;
      end else begin : g_zero
         assign mode_word[b] = 1'b0;
      end
   end

endmodule

// File: rtl/sdram_boot_cmdenc.sv
module sdram_boot_cmdenc
   import sdram_boot_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned BANK_W  = 2,
   parameter int unsigned ALL_BIT = 10
) (
   input  boot_cmd_e         cmd,
   input  logic              pwr_on,
   input  logic [ADDR_W-1:0] mode_word,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] ba
);

   localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << ALL_BIT;

   assign cke  = pwr_on;
   assign cs_n = 1'b0;
   assign ba   = '0;

   always_comb begin
      ras_n = 1'b1;
      cas_n = 1'b1;
      we_n  = 1'b1;
      addr  = '0;
      case (cmd)
         CMD_PRE: begin
            ras_n = 1'b0;
            we_n  = 1'b0;
            addr  = ALL_BANKS;
         end
         CMD_REF: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
         end
         CMD_MRS: begin
            ras_n = 1'b0;
            cas_n = 1'b0;
            we_n  = 1'b0;
            addr  = mode_word;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
   import sdram_boot_pkg::*;
#(
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned BANK_W         = 2,
   parameter int unsigned PWR_WAIT_CYC   = 20000,
   parameter int unsigned T_RP_CYC       = 2,
   parameter int unsigned T_RC_CYC       = 7,
   parameter int unsigned T_MRD_CYC      = 2,
   parameter int unsigned N_REFRESH      = 8,
   parameter bit          MODE_FIRST     = 1'b0,
   parameter int unsigned CAS_LAT        = 2,
   parameter int unsigned BURST_TYPE     = 0,
   parameter int unsigned BURST_LEN_CODE = 2,
   parameter int unsigned SINGLE_WRITE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BANK_W-1:0] sd_ba,
   output logic              init_done
);

   localparam int unsigned MAX_WAIT = max2(max2(PWR_WAIT_CYC, T_RP_CYC),
                                           max2(T_RC_CYC, T_MRD_CYC));
   localparam int unsigned CNT_W = $clog2(MAX_WAIT + 1);
   localparam int unsigned RC_W  = $clog2(N_REFRESH + 1);
   localparam logic [CNT_W-1:0] LD_PWR = CNT_W'(PWR_WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP_CYC - 2);
   localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC_CYC - 2);
   localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD_CYC - 2);
   localparam logic [RC_W-1:0]  LAST_REF = RC_W'(N_REFRESH - 1);

   if (N_REFRESH < 8) begin : g_bad_nref
      $error("sdram_boot_seq: at least eight refreshes are required");
   end
   if (PWR_WAIT_CYC < 1) begin : g_bad_pwr
      $error("sdram_boot_seq: power-up wait must be at least one cycle");
   end
   if (T_RP_CYC < 2 || T_RC_CYC < 2 || T_MRD_CYC < 2) begin : g_bad_gap
      $error("sdram_boot_seq: command gaps must be at least two cycles");
   end
   if (ADDR_W < 11 || BANK_W < 1) begin : g_bad_width
      $error("sdram_boot_seq: address must reach bit 10 and bank must be non-empty");
   end

   boot_phase_e phase_q, phase_d;
   boot_phase_e after_q, after_d;
   boot_phase_e after_pre, after_last_ref, after_mode;
   logic [RC_W-1:0]  ref_cnt_q, ref_cnt_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;
   boot_cmd_e        cmd;
   logic [ADDR_W-1:0] mode_word;

   if (MODE_FIRST) begin : g_mode_first
      assign after_pre      = PH_MODE;
      assign after_mode     = PH_REFRESH;
      assign after_last_ref = PH_DONE;
   end else begin : g_refresh_first
      assign after_pre      = PH_REFRESH;
      assign after_mode     = PH_DONE;
      assign after_last_ref = PH_MODE;
   end

   sdram_boot_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sdram_boot_opcode #(
      .ADDR_W         (ADDR_W),
      .CAS_LAT        (CAS_LAT),
      .BURST_TYPE     (BURST_TYPE),
      .BURST_LEN_CODE (BURST_LEN_CODE),
      .SINGLE_WRITE   (SINGLE_WRITE)
   ) u_opcode (
      .mode_word (mode_word)
   );

   always_comb begin
      phase_d   = phase_q;
      after_d   = after_q;
      ref_cnt_d = ref_cnt_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      case (phase_q)
         PH_IDLE: begin
            phase_d  = PH_POWERUP;
            tmr_load = 1'b1;
            tmr_val  = LD_PWR;
         end
         PH_POWERUP: begin
            if (tmr_expired) phase_d = PH_PRECHARGE;
         end
         PH_PRECHARGE: begin
            phase_d  = PH_GAP;
            tmr_load = 1'b1;
            tmr_val  = LD_RP;
            after_d  = after_pre;
         end
         PH_REFRESH: begin
            phase_d   = PH_GAP;
            tmr_load  = 1'b1;
            tmr_val   = LD_RC;
            ref_cnt_d = ref_cnt_q + RC_W'(1);
            after_d   = (ref_cnt_q == LAST_REF) ? after_last_ref : PH_REFRESH;
         end
         PH_MODE: begin
            phase_d  = PH_GAP;
            tmr_load = 1'b1;
            tmr_val  = LD_MRD;
            after_d  = after_mode;
         end
         PH_GAP: begin
            if (tmr_expired) phase_d = after_q;
         end
         PH_DONE: ;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         after_q   <= PH_IDLE;
         ref_cnt_q <= '0;
      end else begin
         phase_q   <= phase_d;
         after_q   <= after_d;
         ref_cnt_q <= ref_cnt_d;
      end
   end

   always_comb begin
      case (phase_q)
         PH_PRECHARGE: cmd = CMD_PRE;
         PH_REFRESH:   cmd = CMD_REF;
         PH_MODE:      cmd = CMD_MRS;
         default:      cmd = CMD_NOP;
      endcase
   end

   sdram_boot_cmdenc #(
      .ADDR_W  (ADDR_W),
      .BANK_W  (BANK_W),
      .ALL_BIT (10)
   ) u_cmdenc (
      .cmd       (cmd),
      .pwr_on    (phase_q != PH_IDLE),
      .mode_word (mode_word),
      .cke       (sd_cke),
      .cs_n      (sd_cs_n),
      .ras_n     (sd_ras_n),
      .cas_n     (sd_cas_n),
      .we_n      (sd_we_n),
      .addr      (sd_addr),
      .ba        (sd_ba)
   );

   assign init_done = (phase_q == PH_DONE);

   logic pin_nop, pin_pre, pin_mrs, pin_cmd;
   assign pin_nop = !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n;
   assign pin_pre = !sd_cs_n && !sd_ras_n && sd_cas_n && !sd_we_n;
   assign pin_mrs = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;
   assign pin_cmd = !sd_ras_n || !sd_cas_n || !sd_we_n;

   assert_cke_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sd_cke |=> sd_cke);

   assert_cke_before_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pin_cmd |-> $past(sd_cke));

   assert_all_bank_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pre |-> (sd_addr[10] && sd_ba == '0));

   assert_refresh_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cnt_q <= RC_W'(N_REFRESH));

   assert_mode_reserved_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pin_mrs |-> (sd_ba == '0 && sd_addr[8:7] == 2'b00 && sd_addr[ADDR_W-1:10] == '0));

   assert_cmd_then_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pin_cmd |=> pin_nop);

   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (pin_nop && ref_cnt_q == RC_W'(N_REFRESH)));

endmodule

// File: tb/sdram_boot_seq_bench.sv
`timescale 1ns/1ps
module sdram_boot_seq_bench;

   localparam int AW = 12;
   localparam int BW = 2;

   // instance A: refresh first
   localparam int A_TP = 5, A_RP = 2, A_RC = 3, A_MRD = 2, A_N = 8;
   localparam int A_CL = 3, A_BT = 1, A_BL = 3, A_SW = 1;
   // instance B: mode load first
   localparam int B_TP = 3, B_RP = 3, B_RC = 4, B_MRD = 3, B_N = 9;
   localparam int B_CL = 2, B_BT = 0, B_BL = 2, B_SW = 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic a_cke, a_cs, a_ras, a_cas, a_we, a_done;
   logic [AW-1:0] a_addr;
   logic [BW-1:0] a_ba;
   logic b_cke, b_cs, b_ras, b_cas, b_we, b_done;
   logic [AW-1:0] b_addr;
   logic [BW-1:0] b_ba;

   sdram_boot_seq #(
      .ADDR_W(AW), .BANK_W(BW), .PWR_WAIT_CYC(A_TP), .T_RP_CYC(A_RP),
      .T_RC_CYC(A_RC), .T_MRD_CYC(A_MRD), .N_REFRESH(A_N), .MODE_FIRST(1'b0),
      .CAS_LAT(A_CL), .BURST_TYPE(A_BT), .BURST_LEN_CODE(A_BL), .SINGLE_WRITE(A_SW)
   ) u_sdram_boot_seq (
      .clk(clk), .rst_n(rst_n), .sd_cke(a_cke), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
      .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_addr(a_addr), .sd_ba(a_ba),
      .init_done(a_done)
   );

   sdram_boot_seq #(
      .ADDR_W(AW), .BANK_W(BW), .PWR_WAIT_CYC(B_TP), .T_RP_CYC(B_RP),
      .T_RC_CYC(B_RC), .T_MRD_CYC(B_MRD), .N_REFRESH(B_N), .MODE_FIRST(1'b1),
      .CAS_LAT(B_CL), .BURST_TYPE(B_BT), .BURST_LEN_CODE(B_BL), .SINGLE_WRITE(B_SW)
   ) u_sdram_boot_seq_alt (
      .clk(clk), .rst_n(rst_n), .sd_cke(b_cke), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
      .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_addr(b_addr), .sd_ba(b_ba),
      .init_done(b_done)
   );

   int checks = 0;
   int fails  = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // 0 nop, 1 precharge-all, 2 refresh, 3 mode load
   function automatic int cmd_at(input int n, input int tp, input int trp, input int trc,
                                 input int tmrd, input int nref, input bit mf);
      int first;
      if (n == tp + 1) return 1;
      first = tp + 1 + trp;
      if (!mf) begin
         for (int i = 0; i < nref; i++) if (n == first + i * trc) return 2;
         if (n == first + nref * trc) return 3;
      end else begin
         if (n == first) return 3;
         for (int i = 0; i < nref; i++) if (n == first + tmrd + i * trc) return 2;
      end
      return 0;
   endfunction

   function automatic int done_at(input int tp, input int trp, input int trc,
                                  input int tmrd, input int nref);
      return tp + 1 + trp + tmrd + nref * trc;
   endfunction

   function automatic logic [31:0] pin_vec(input logic cke, input int code, input int op);
      logic [3:0]    ctl;
      logic [AW-1:0] ad;
      ad = '0;
      case (code)
         1: begin ctl = 4'b0010; ad = AW'(1) << 10; end
         2: ctl = 4'b0001;
         3: begin ctl = 4'b0000; ad = AW'(op); end
         default: ctl = 4'b0111;
      endcase
      return 32'({cke, ctl, {BW{1'b0}}, ad});
   endfunction

   function automatic string tag_of(input int code, input bit mf);
      string ord;
      ord = mf ? "R7" : "R6";
      case (code)
         1: return {"R3 R2 ", ord};
         2: return {"R4 ", ord};
         3: return {"R5 ", ord};
         default: return "R8 R2";
      endcase
   endfunction

   int op_a, op_b, done_a, done_b;

   task automatic check_reset(input string req);
      check($sformatf("%s reset pins A", req),
            32'({a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr}), pin_vec(1'b0, 0, 0));
      check($sformatf("%s reset done A", req), 32'(a_done), 32'd0);
      check($sformatf("%s reset pins B", req),
            32'({b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr}), pin_vec(1'b0, 0, 0));
      check($sformatf("%s reset done B", req), 32'(b_done), 32'd0);
   endtask

   task automatic sweep(input int last, input string ctx);
      for (int n = 1; n <= last; n++) begin
         int ca, cb;
         @(posedge clk);
         @(negedge clk);
         ca = cmd_at(n, A_TP, A_RP, A_RC, A_MRD, A_N, 1'b0);
         cb = cmd_at(n, B_TP, B_RP, B_RC, B_MRD, B_N, 1'b1);
         check($sformatf("%s %s cycle %0d inst A", tag_of(ca, 1'b0), ctx, n),
               32'({a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr}), pin_vec(1'b1, ca, op_a));
         check($sformatf("R9 R6 %s done cycle %0d inst A", ctx, n),
               32'(a_done), 32'(n >= done_a));
         check($sformatf("%s %s cycle %0d inst B", tag_of(cb, 1'b1), ctx, n),
               32'({b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr}), pin_vec(1'b1, cb, op_b));
         check($sformatf("R9 R7 %s done cycle %0d inst B", ctx, n),
               32'(b_done), 32'(n >= done_b));
      end
   endtask

   initial begin
      op_a   = A_SW * 512 + A_CL * 16 + A_BT * 8 + A_BL;
      op_b   = B_SW * 512 + B_CL * 16 + B_BT * 8 + B_BL;
      done_a = done_at(A_TP, A_RP, A_RC, A_MRD, A_N);
      done_b = done_at(B_TP, B_RP, B_RC, B_MRD, B_N);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_reset("R1");
      rst_n = 1'b1;
      sweep(52, "first run");
      rst_n = 1'b0;
      #1;
      check_reset("R10");
      @(negedge clk);
      rst_n = 1'b1;
      sweep(20, "partial run");
      rst_n = 1'b0;
      #1;
      check_reset("R10");
      repeat (2) @(negedge clk);
      check_reset("R10");
      rst_n = 1'b1;
      sweep(52, "R10 restart");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #100000;
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual still running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule